// File: doc/BRIEF.md
# Four-Way Set-Associative Instruction Fetch Cache

This block is a read-only instruction cache that sits between a fetch unit and a word-wide memory port. It holds 32 lines of one 32-bit word each, arranged as eight sets of four ways. A fetch address picks a set through bits [4:2]. The remaining upper bits, [63:5], form the tag, and that tag is compared against all four ways of the set in the same cycle. The two lowest address bits are a byte offset, and the cache ignores them.

On a hit the cached word comes back one cycle after the request is accepted. On a miss the block issues a single-word memory read and holds it until the memory acknowledges. It then writes the word into a victim way of the addressed set and returns the word in the following cycle. The victim is chosen by least-recently-used replacement built on a logical clock. A 32-bit reference counter advances on every accepted lookup, and each hit or fill stamps the touched way with the new count. The victim is the lowest-numbered invalid way if the set has one. Otherwise it is the way with the smallest stamp, and the lowest number wins a tie. Running hit and miss counters are kept alongside the reference counter.

Top module: `fetch_cache`

## Requirements
- R1: After a synchronous active-high reset, every line is invalid, the three counters read zero, and resp_valid, mem_req and cpu_busy are low.
- R2: Bits [4:2] of cpu_addr select the set and bits [63:5] form the tag. Bits [1:0] are ignored, so an address that differs from a cached one only in those bits hits and returns the same word.
- R3: A lookup is accepted when cpu_req is high and cpu_busy is low. On a hit, resp_valid is high with resp_hit = 1 and the stored word in the next cycle, and no memory read is issued.
- R4: On a miss, mem_req rises in the cycle after acceptance, with mem_addr equal to the request address with bits [1:0] cleared. mem_req and mem_addr then hold until mem_ack. In the cycle after mem_ack, resp_valid is high with resp_hit = 0 and resp_data equal to the mem_data sampled with mem_ack.
- R5: A miss into a set that has invalid ways fills the lowest-numbered invalid way, so four distinct tags in one empty set all stay resident.
- R6: A miss into a full set evicts the way with the smallest stamp, which is the least recently used line. A later access to the evicted tag misses, and the other three tags still hit.
- R7: A hit restamps its way with the current reference count, so a line that has just hit is not the next victim.
- R8: ref_count rises by one for every accepted lookup, hit_count for every hit, and miss_count for every miss. ref_count always equals hit_count + miss_count.
- R9: Sets are independent. The same tag in two sets occupies two lines, and fills in one set never evict lines of another.
- R10: While cpu_busy is high (a miss is outstanding), cpu_req is ignored. No counter changes and no extra response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Lookup request, accepted when cpu_busy is low |
| cpu_addr | input | 64 | Byte address of the fetch |
| cpu_busy | output | 1 | A miss is outstanding; requests are ignored |
| resp_valid | output | 1 | One-cycle pulse carrying a response |
| resp_hit | output | 1 | 1 if the response came from the cache, 0 if it came from memory |
| resp_data | output | 32 | Returned instruction word |
| mem_req | output | 1 | Memory read request, held until mem_ack |
| mem_addr | output | 64 | Word-aligned memory read address |
| mem_ack | input | 1 | Memory has supplied mem_data this cycle |
| mem_data | input | 32 | Word from memory |
| ref_count | output | 32 | Accepted lookups since reset, also the recency clock |
| hit_count | output | 32 | Hits since reset |
| miss_count | output | 32 | Misses since reset |

## Verification
The assertions assume that mem_ack is raised only while mem_req is high, that memory returns a stable word for a given address, and that the reference counter does not wrap. The bench's memory model acknowledges only an outstanding request, after a fixed delay, and returns a word derived from the address. The stimulus stays far below 2^32 lookups. The stimulus also issues requests only when cpu_busy is low, apart from one deliberate poke during a miss that exercises the ignore rule.

// File: rtl/fetch_cache_pkg.sv
package fetch_cache_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } fc_state_t;
endpackage

// File: rtl/fc_line_store.sv
module fc_line_store #(
  parameter int SETS    = 8,
  parameter int WAYS    = 4,
  parameter int TAG_W   = 59,
  parameter int DATA_W  = 32,
  parameter int STAMP_W = 32,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int SLOTS  = SETS * WAYS
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [SET_W-1:0]                rd_set,
  output logic [WAYS-1:0]                 rd_valid,
  output logic [WAYS-1:0][TAG_W-1:0]      rd_tag,
  output logic [WAYS-1:0][DATA_W-1:0]     rd_data,
  output logic [WAYS-1:0][STAMP_W-1:0]    rd_stamp,
  input  logic                            wr_en,
  input  logic                            wr_fill,
  input  logic [SET_W-1:0]                wr_set,
  input  logic [WAY_W-1:0]                wr_way,
  input  logic [TAG_W-1:0]                wr_tag,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic [STAMP_W-1:0]              wr_stamp
);
  logic [SLOTS-1:0]   valid_q;
  logic [TAG_W-1:0]   tag_mem   [SLOTS];
  logic [DATA_W-1:0]  data_mem  [SLOTS];
  logic [STAMP_W-1:0] stamp_mem [SLOTS];

  logic [$clog2(SLOTS)-1:0] wr_slot;
  assign wr_slot = {wr_set, wr_way};

  // valid bits need a reset; the arrays do not
  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en && wr_fill) valid_q[wr_slot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      stamp_mem[wr_slot] <= wr_stamp;
      if (wr_fill) begin
        tag_mem[wr_slot]  <= wr_tag;
        data_mem[wr_slot] <= wr_data;
      end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    localparam logic [WAY_W-1:0] WI = WAY_W'(w);
    assign rd_valid[w] = valid_q[{rd_set, WI}];
    assign rd_tag[w]   = tag_mem[{rd_set, WI}];
    assign rd_data[w]  = data_mem[{rd_set, WI}];
    assign rd_stamp[w] = stamp_mem[{rd_set, WI}];
  end
endmodule

// File: rtl/fc_tag_match.sv
module fc_tag_match #(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 59,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]           probe_tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = way_valid[w] && (way_tag[w] == probe_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (match[w]) hit_way = WAY_W'(w);
  end
  assign hit = |match;

  // R5/R9: a fill never duplicates a resident tag, so at most one way matches
  a_r5_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
endmodule

// File: rtl/fc_victim_pick.sv
module fc_victim_pick #(
  parameter int WAYS    = 4,
  parameter int STAMP_W = 32,
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [WAYS-1:0]              way_valid,
  input  logic [WAYS-1:0][STAMP_W-1:0] way_stamp,
  output logic [WAY_W-1:0]             victim
);
  logic [WAY_W-1:0]   free_way;
  logic               have_free;
  logic [WAY_W-1:0]   old_way;
  logic [STAMP_W-1:0] old_stamp;

  always_comb begin
    have_free = 1'b0;
    free_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!way_valid[w]) begin
        have_free = 1'b1;
        free_way  = WAY_W'(w);
      end
  end

  // strict less-than keeps the lowest way on a tie
  always_comb begin
    old_way   = '0;
    old_stamp = way_stamp[0];
    for (int w = 1; w < WAYS; w++)
      if (way_stamp[w] < old_stamp) begin
        old_way   = WAY_W'(w);
        old_stamp = way_stamp[w];
      end
  end

  assign victim = have_free ? free_way : old_way;

  // R5: with a free way present, a valid line is never chosen
  a_r5_free_first: assert property (@(posedge clk) disable iff (rst)
    !(&way_valid) |-> !way_valid[victim]);

  for (genvar g = 0; g < WAYS; g++) begin : g_chk
    // R6: in a full set the victim carries no larger stamp than any way
    a_r6_oldest: assert property (@(posedge clk) disable iff (rst)
      (&way_valid) |-> (way_stamp[victim] <= way_stamp[g]));
  end
endmodule

// File: rtl/fetch_cache.sv
module fetch_cache
  import fetch_cache_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int DATA_W   = 32,
  parameter int SETS     = 8,
  parameter int WAYS     = 4,
  parameter int CNT_W    = 32,
  localparam int OFF_W   = 2,
  localparam int SET_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int TAG_LSB = OFF_W + SET_W,
  localparam int TAG_W   = ADDR_W - TAG_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_busy,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_data,
  output logic [CNT_W-1:0]  ref_count,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  fc_state_t state;

  logic [SET_W-1:0] req_set;
  logic [TAG_W-1:0] req_tag;
  assign req_set = cpu_addr[TAG_LSB-1:OFF_W];
  assign req_tag = cpu_addr[ADDR_W-1:TAG_LSB];

  logic [WAYS-1:0]              rd_valid;
  logic [WAYS-1:0][TAG_W-1:0]   rd_tag;
  logic [WAYS-1:0][DATA_W-1:0]  rd_data;
  logic [WAYS-1:0][CNT_W-1:0]   rd_stamp;
  logic                         hit;
  logic [WAY_W-1:0]             hit_way;
  logic [WAY_W-1:0]             victim;

  logic [SET_W-1:0] fill_set;
  logic [TAG_W-1:0] fill_tag;
  logic [WAY_W-1:0] fill_way;

  logic accept, fill_now;
  logic             wr_en, wr_fill;
  logic [SET_W-1:0] wr_set;
  logic [WAY_W-1:0] wr_way;
  logic [CNT_W-1:0] wr_stamp;

  assign cpu_busy = (state != ST_IDLE);
  assign accept   = cpu_req && (state == ST_IDLE);
  assign fill_now = (state == ST_FILL) && mem_ack;

  // a hit restamps with the advanced count; a fill uses the count already advanced
  assign wr_en    = (accept && hit) || fill_now;
  assign wr_fill  = (state == ST_FILL);
  assign wr_set   = wr_fill ? fill_set : req_set;
  assign wr_way   = wr_fill ? fill_way : hit_way;
  assign wr_stamp = wr_fill ? ref_count : ref_count + 1'b1;

  fc_line_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W), .STAMP_W(CNT_W)
  ) u_store (
    .clk(clk), .rst(rst), .rd_set(req_set),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data), .rd_stamp(rd_stamp),
    .wr_en(wr_en), .wr_fill(wr_fill), .wr_set(wr_set), .wr_way(wr_way),
    .wr_tag(fill_tag), .wr_data(mem_data), .wr_stamp(wr_stamp)
  );

  fc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .clk(clk), .rst(rst), .way_valid(rd_valid), .way_tag(rd_tag),
    .probe_tag(req_tag), .hit(hit), .hit_way(hit_way)
  );

  fc_victim_pick #(.WAYS(WAYS), .STAMP_W(CNT_W)) u_victim (
    .clk(clk), .rst(rst), .way_valid(rd_valid), .way_stamp(rd_stamp),
    .victim(victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      mem_req    <= 1'b0;
      ref_count  <= '0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (accept) begin
        ref_count <= ref_count + 1'b1;
        if (hit) begin
          hit_count  <= hit_count + 1'b1;
          resp_valid <= 1'b1;
          resp_hit   <= 1'b1;
        end else begin
          miss_count <= miss_count + 1'b1;
          mem_req    <= 1'b1;
          state      <= ST_FILL;
        end
      end else if (fill_now) begin
        mem_req    <= 1'b0;
        state      <= ST_IDLE;
        resp_valid <= 1'b1;
        resp_hit   <= 1'b0;
      end
    end
  end

  // datapath registers without reset
  always_ff @(posedge clk) begin
    if (accept && hit) resp_data <= rd_data[hit_way];
    else if (fill_now) resp_data <= mem_data;
    if (accept && !hit) begin
      mem_addr <= {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      fill_set <= req_set;
      fill_tag <= req_tag;
      fill_way <= victim;
    end
  end

  a_r8_count_sum: assert property (@(posedge clk) disable iff (rst)
    ref_count == hit_count + miss_count);

  a_r4_hold_req: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  a_r4_resp_after_fill: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> (resp_valid && !resp_hit && !mem_req));

  a_r3_hit_resp: assert property (@(posedge clk) disable iff (rst)
    (accept && hit) |=> (resp_valid && resp_hit && !mem_req));

  a_r10_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    cpu_busy |=> $stable(ref_count));
endmodule

// File: tb/sim_fetch_cache.sv
module sim_fetch_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0;
  logic [63:0] cpu_addr = '0;
  logic        cpu_busy, resp_valid, resp_hit;
  logic [31:0] resp_data;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_data = '0;
  logic [31:0] ref_count, hit_count, miss_count;

  always #4 clk = ~clk;   // 125 MHz

  fetch_cache u0 (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_busy(cpu_busy), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_data(resp_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_data(mem_data), .ref_count(ref_count),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int issued   = 0;
  int seen     = 0;
  int fetches  = 0;
  bit done     = 0;

  logic [32:0] exp_q[$];
  string       req_q[$];
  logic [63:0] fetch_q[$];

  function automatic logic [31:0] memword(input logic [63:0] a);
    return a[31:0] ^ 32'hDEAD_0000 ^ {a[39:32], 24'h0};
  endfunction

  function automatic logic [63:0] mk(input int tag, input int set, input int off);
    return (64'(tag) << 5) | (64'(set) << 2) | 64'(off);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pop the expected response and compare
  always @(negedge clk) begin
    if (!rst && resp_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R10", "unexpected response", 64'(resp_data), 0);
      end else begin
        logic [32:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(resp_data == e[31:0], r, "resp_data", 64'(resp_data), 64'(e[31:0]));
        check(resp_hit == e[32], r, "resp_hit", 64'(resp_hit), 64'(e[32]));
      end
      seen++;
    end
  end

  // memory model: fixed delay, checks the fetch address once per request (R4)
  int  mdelay = 0;
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (!rst && mem_req) begin
      if (mdelay == 0) begin
        logic [63:0] ef;
        fetches++;
        ef = (fetch_q.size() != 0) ? fetch_q.pop_front() : 64'hX;
        check(mem_addr === ef, "R4", "mem_addr", mem_addr, ef);
      end
      mdelay++;
      if (mdelay == 3) begin
        mem_ack  = 1'b1;
        mem_data = memword(mem_addr);
        mdelay   = 0;
      end
    end
  end

  task automatic access(input logic [63:0] a, input bit exp_hit,
                        input string req, input bit poke);
    @(negedge clk);
    while (cpu_busy) @(negedge clk);
    exp_q.push_back({exp_hit, memword(a & ~64'd3)});
    req_q.push_back(req);
    if (!exp_hit) fetch_q.push_back(a & ~64'd3);
    cpu_req  = 1'b1;
    cpu_addr = a;
    issued++;
    @(negedge clk);
    cpu_req = 1'b0;
    if (poke) begin
      // R10: request while a miss is outstanding must be dropped
      cpu_req  = 1'b1;
      cpu_addr = mk(9, 2, 0);
      @(negedge clk);
      cpu_req = 1'b0;
    end
    while (seen != issued) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(resp_valid == 0, "R1", "resp_valid", 64'(resp_valid), 0);
    check(mem_req == 0, "R1", "mem_req", 64'(mem_req), 0);
    check(cpu_busy == 0, "R1", "cpu_busy", 64'(cpu_busy), 0);
    check(ref_count == 0 && hit_count == 0 && miss_count == 0, "R1", "counters",
          64'(ref_count + hit_count + miss_count), 0);

    access(mk(1, 0, 0), 0, "R1", 0);         // empty cache misses: A -> way0
    access(mk(2, 0, 0), 0, "R5", 0);         // B -> way1
    access(mk(1, 0, 0), 1, "R3", 0);         // A hits, restamp
    check(ref_count == 3, "R8", "ref_count", 64'(ref_count), 3);
    access(mk(3, 0, 0), 0, "R5", 0);         // C -> way2
    access(mk(4, 0, 0), 0, "R5", 0);         // D -> way3, set full
    access(mk(5, 0, 0), 0, "R7", 0);         // E evicts B, not restamped A
    access(mk(1, 0, 0), 1, "R7", 0);         // A survived
    access(mk(2, 0, 0), 0, "R6", 1);         // B evicted earlier; evicts C; poke
    access(mk(3, 0, 0), 0, "R6", 0);         // C evicted; evicts D
    access(mk(5, 0, 0), 1, "R6", 0);         // E still resident
    access(mk(1, 0, 3), 1, "R2", 0);         // byte offset ignored
    access(mk(1, 1, 0), 0, "R9", 0);         // same tag, other set
    access(mk(1, 0, 0), 1, "R9", 0);         // set 0 untouched
    access(mk(4, 0, 2), 0, "R6", 0);         // D was evicted

    repeat (3) @(negedge clk);
    check(ref_count == 14, "R10", "ref_count", 64'(ref_count), 14);
    check(hit_count == 5, "R8", "hit_count", 64'(hit_count), 5);
    check(miss_count == 9, "R8", "miss_count", 64'(miss_count), 9);
    check(fetches == 9, "R3", "memory fetches", 64'(fetches), 9);
    check(exp_q.size() == 0, "R10", "pending responses", 64'(exp_q.size()), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d responses expected %0d", seen, issued);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule